// File: doc/BRIEF.md
# Audio Serial Port Mode Selector and Clock Generator

This block settles the operating configuration of an audio converter's serial port. Three settings can come from either of two places: master or slave role, master-clock-to-sample-rate ratio, and data format. They come from register fields written by software, or from strap pins wired on the board. A pin-control enable picks the source. When strap control is active, every other configurable function is forced to its power-on default, and the register contents are ignored.

In master mode the block divides the master clock to make the bit clock and the left/right frame clock, and enables their output drivers. In slave mode it turns the drivers off and passes the incoming clocks straight to the internal users. The strap pins and the pin-control enable go through a synchronizer. Any change in the resolved configuration restarts the dividers from a known phase.

Top module: `aud_sport_mode_ctl`

## Requirements
- R1: While the synchronized pin-control enable is 1, the resolved settings come from the strap pins. Role follows `strap_slave`. The ratio code is 2'b00 when `strap_ratio_hi` is 0 and 2'b01 when it is 1. `fmt_code` equals `strap_fmt`.
- R2: While pin control is inactive, role, ratio code and format come from `cfg_slave`, `cfg_ratio` and `cfg_fmt`, one clock after they are applied.
- R3: While pin control is active, `misc_eff` stays at the power-on default (8'h00 by default) whatever `cfg_misc` holds. Under register control, `misc_eff` follows `cfg_misc`.
- R4: A role value of 0 means master, with `bclk_oe` and `lrclk_oe` at 1. A role value of 1 means slave, with both enables at 0 and `bclk_out` and `lrclk_out` at 0. The reset state is slave.
- R5: In slave mode, `bclk_int` and `lrclk_int` equal `bclk_in` and `lrclk_in`.
- R6: In master mode with 64 bit clocks per frame, the `bclk_out` period is 4 master-clock cycles for ratio code 2'b00 (256 fs), 8 for 2'b01 (512 fs) and 16 for 2'b10 (1024 fs). Code 2'b11 behaves as 2'b00.
- R7: `lrclk_out` changes only in the cycle where `bclk_out` falls. It changes once every 32 bit-clock periods: 0 for the left half of the frame and 1 for the right half.
- R8: A change on a strap pin reaches the resolved outputs on the third rising master-clock edge after it is applied.
- R9: When role, ratio code or format changes, `bclk_out` and `lrclk_out` are both 0 in that cycle. The first rising bit-clock edge then comes half a bit-clock period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_ctl_en | input | 1 | Selects strap-pin control when 1 |
| strap_slave | input | 1 | Strap role: 0 master, 1 slave |
| strap_ratio_hi | input | 1 | Strap ratio: 0 for 256 fs, 1 for 512 fs |
| strap_fmt | input | 2 | Strap data format code |
| cfg_slave | input | 1 | Register role bit |
| cfg_ratio | input | 2 | Register ratio code |
| cfg_fmt | input | 2 | Register data format code |
| cfg_misc | input | MISC_W | Register bits for all other functions |
| bclk_in | input | 1 | Bit clock from outside (slave) |
| lrclk_in | input | 1 | Frame clock from outside (slave) |
| mode_pinctl | output | 1 | Strap control is in effect |
| mode_slave | output | 1 | Resolved role |
| mode_ratio | output | 2 | Resolved ratio code |
| fmt_code | output | 2 | Resolved data format code |
| misc_eff | output | MISC_W | Effective value of the other functions |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit clock driver enable |
| lrclk_out | output | 1 | Generated frame clock |
| lrclk_oe | output | 1 | Frame clock driver enable |
| bclk_int | output | 1 | Bit clock for internal users |
| lrclk_int | output | 1 | Frame clock for internal users |

## Verification
The hardest case to reach is a strap change landing in the middle of a running frame. It has to show both the three-edge latency and a divider restart from phase zero. The stimulus holds register and strap settings that differ on purpose, so the bench can tell which source is visible on each edge. It changes one input on a falling edge and samples the resolved code and the clocks on the falling edges that follow. Bit-clock periods and frame lengths are measured from the port waveforms after each configuration has settled.

// File: rtl/aspm_pkg.sv
package aspm_pkg;

   typedef struct packed {
      logic       slave;
      logic [1:0] ratio;
      logic [1:0] fmt;
   } port_cfg_t;

   localparam logic [1:0] RATIO_256  = 2'b00;
   localparam logic [1:0] RATIO_512  = 2'b01;
   localparam logic [1:0] RATIO_1024 = 2'b10;
   localparam int         RATIO_LOG_MAX = 10;

   // log2 of master clock cycles per frame for a ratio code
   function automatic int ratio_log2(input logic [1:0] code);
      case (code)
         RATIO_512:  return 9;
         RATIO_1024: return 10;
         default:    return 8;
      endcase
   endfunction

endpackage

// File: rtl/aspm_sync.sv
module aspm_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("aspm_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/aspm_resolve.sv
module aspm_resolve
   import aspm_pkg::*;
#(
   parameter int                MISC_W    = 8,
   parameter logic [MISC_W-1:0] MISC_DFLT = '0
) (
   input  logic              pin_ctl,
   input  logic              s_slave,
   input  logic              s_ratio_hi,
   input  logic [1:0]        s_fmt,
   input  logic              r_slave,
   input  logic [1:0]        r_ratio,
   input  logic [1:0]        r_fmt,
   input  logic [MISC_W-1:0] r_misc,
   output port_cfg_t         cfg,
   output logic [MISC_W-1:0] misc
);

   always_comb begin
      if (pin_ctl) begin
         cfg.slave = s_slave;
         cfg.ratio = s_ratio_hi ? RATIO_512 : RATIO_256;
         cfg.fmt   = s_fmt;
         misc      = MISC_DFLT;
      end else begin
         cfg.slave = r_slave;
         cfg.ratio = r_ratio;
         cfg.fmt   = r_fmt;
         misc      = r_misc;
      end
   end

endmodule

// File: rtl/aspm_clkdiv.sv
module aspm_clkdiv
   import aspm_pkg::*;
#(
   parameter int FRAME_LOG = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [1:0] ratio,
   output logic       bclk,
   output logic       lrclk
);

   localparam int CNT_W = RATIO_LOG_MAX;
   localparam int IDX_W = $clog2(CNT_W);

   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] bidx, lidx;

   // free-running counter: low bits repeat every frame for any ratio
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || restart)  cnt <= '0;
      else                       cnt <= cnt + 1'b1;
   end

   always_comb begin
      int lg;
      lg   = ratio_log2(ratio);
      bidx = IDX_W'(lg - FRAME_LOG - 1);
      lidx = IDX_W'(lg - 1);
   end

   assign bclk  = run & cnt[bidx];
   assign lrclk = run & cnt[lidx];

endmodule

// File: rtl/aud_sport_mode_ctl.sv
module aud_sport_mode_ctl
   import aspm_pkg::*;
#(
   parameter int                MISC_W      = 8,
   parameter logic [MISC_W-1:0] MISC_DFLT   = '0,
   parameter int                SYNC_STAGES = 2,
   parameter int                FRAME_BITS  = 64
) (
   input  logic              mclk,
   input  logic              rst_n,
   input  logic              pin_ctl_en,
   input  logic              strap_slave,
   input  logic              strap_ratio_hi,
   input  logic [1:0]        strap_fmt,
   input  logic              cfg_slave,
   input  logic [1:0]        cfg_ratio,
   input  logic [1:0]        cfg_fmt,
   input  logic [MISC_W-1:0] cfg_misc,
   input  logic              bclk_in,
   input  logic              lrclk_in,
   output logic              mode_pinctl,
   output logic              mode_slave,
   output logic [1:0]        mode_ratio,
   output logic [1:0]        fmt_code,
   output logic [MISC_W-1:0] misc_eff,
   output logic              bclk_out,
   output logic              bclk_oe,
   output logic              lrclk_out,
   output logic              lrclk_oe,
   output logic              bclk_int,
   output logic              lrclk_int
);

   localparam int FRAME_LOG = $clog2(FRAME_BITS);
   localparam int SYNC_W    = 5;

   if ((1 << FRAME_LOG) != FRAME_BITS || FRAME_LOG < 2 || FRAME_LOG > 7) begin : g_bad_frame
      $error("aud_sport_mode_ctl: FRAME_BITS must be a power of two from 4 to 128");
   end
   if (MISC_W < 1) begin : g_bad_misc
      $error("aud_sport_mode_ctl: MISC_W must be positive");
   end

   logic [SYNC_W-1:0] strap_s;
   port_cfg_t         cfg_d, cfg_q;
   logic [MISC_W-1:0] misc_d;
   logic              gen_bclk, gen_lrclk;

   aspm_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (mclk),
      .rst_n (rst_n),
      .d     ({pin_ctl_en, strap_slave, strap_ratio_hi, strap_fmt}),
      .q     (strap_s)
   );

   aspm_resolve #(.MISC_W(MISC_W), .MISC_DFLT(MISC_DFLT)) u_resolve (
      .pin_ctl    (strap_s[4]),
      .s_slave    (strap_s[3]),
      .s_ratio_hi (strap_s[2]),
      .s_fmt      (strap_s[1:0]),
      .r_slave    (cfg_slave),
      .r_ratio    (cfg_ratio),
      .r_fmt      (cfg_fmt),
      .r_misc     (cfg_misc),
      .cfg        (cfg_d),
      .misc       (misc_d)
   );

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q       <= '{slave: 1'b1, ratio: RATIO_256, fmt: 2'b00};
         misc_eff    <= MISC_DFLT;
         mode_pinctl <= 1'b0;
      end else begin
         cfg_q       <= cfg_d;
         misc_eff    <= misc_d;
         mode_pinctl <= strap_s[4];
      end
   end

   aspm_clkdiv #(.FRAME_LOG(FRAME_LOG)) u_div (
      .clk     (mclk),
      .rst_n   (rst_n),
      .run     (~cfg_q.slave),
      .restart (cfg_d != cfg_q),
      .ratio   (cfg_q.ratio),
      .bclk    (gen_bclk),
      .lrclk   (gen_lrclk)
   );

   assign mode_slave = cfg_q.slave;
   assign mode_ratio = cfg_q.ratio;
   assign fmt_code   = cfg_q.fmt;
   assign bclk_out   = gen_bclk;
   assign lrclk_out  = gen_lrclk;
   assign bclk_oe    = ~cfg_q.slave;
   assign lrclk_oe   = ~cfg_q.slave;
   assign bclk_int   = cfg_q.slave ? bclk_in  : gen_bclk;
   assign lrclk_int  = cfg_q.slave ? lrclk_in : gen_lrclk;

endmodule

// File: rtl/aud_sport_mode_ctl_chk.sv
module aud_sport_mode_ctl_chk #(
   parameter int                MISC_W    = 8,
   parameter logic [MISC_W-1:0] MISC_DFLT = '0
) (
   input logic              mclk,
   input logic              rst_n,
   input logic              mode_pinctl,
   input logic              mode_slave,
   input logic [1:0]        mode_ratio,
   input logic [1:0]        fmt_code,
   input logic [MISC_W-1:0] misc_eff,
   input logic              bclk_out,
   input logic              bclk_oe,
   input logic              lrclk_out,
   input logic              lrclk_oe,
   input logic              bclk_int,
   input logic              lrclk_int,
   input logic              bclk_in,
   input logic              lrclk_in
);

   a_r4_slave_quiet: assert property (@(posedge mclk) disable iff (!rst_n)
      mode_slave |-> (!bclk_oe && !lrclk_oe && !bclk_out && !lrclk_out));

   a_r5_slave_pass: assert property (@(posedge mclk) disable iff (!rst_n)
      mode_slave |-> (bclk_int == bclk_in && lrclk_int == lrclk_in));

   a_r3_misc_default: assert property (@(posedge mclk) disable iff (!rst_n)
      mode_pinctl |=> (mode_pinctl -> misc_eff == MISC_DFLT));

   a_r7_lr_on_bclk_fall: assert property (@(posedge mclk) disable iff (!rst_n)
      (!mode_slave && mode_ratio == $past(mode_ratio) && mode_slave == $past(mode_slave)
       && fmt_code == $past(fmt_code) && lrclk_out != $past(lrclk_out)) |-> $fell(bclk_out));

   a_r9_restart_phase: assert property (@(posedge mclk) disable iff (!rst_n)
      (mode_ratio != $past(mode_ratio) || mode_slave != $past(mode_slave)
       || fmt_code != $past(fmt_code)) |-> (!bclk_out && !lrclk_out));

endmodule

bind aud_sport_mode_ctl aud_sport_mode_ctl_chk #(.MISC_W(MISC_W), .MISC_DFLT(MISC_DFLT)) u_chk (
   .mclk        (mclk),
   .rst_n       (rst_n),
   .mode_pinctl (mode_pinctl),
   .mode_slave  (mode_slave),
   .mode_ratio  (mode_ratio),
   .fmt_code    (fmt_code),
   .misc_eff    (misc_eff),
   .bclk_out    (bclk_out),
   .bclk_oe     (bclk_oe),
   .lrclk_out   (lrclk_out),
   .lrclk_oe    (lrclk_oe),
   .bclk_int    (bclk_int),
   .lrclk_int   (lrclk_int),
   .bclk_in     (bclk_in),
   .lrclk_in    (lrclk_in)
);

// File: tb/aud_sport_mode_ctl_tb.sv
module aud_sport_mode_ctl_tb;

   logic       mclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_ctl_en = 1'b0, strap_slave = 1'b0, strap_ratio_hi = 1'b0;
   logic [1:0] strap_fmt = '0, cfg_ratio = '0, cfg_fmt = '0;
   logic       cfg_slave = 1'b1;
   logic [7:0] cfg_misc = '0;
   logic       bclk_in = 1'b0, lrclk_in = 1'b0;
   logic       mode_pinctl, mode_slave, bclk_out, bclk_oe, lrclk_out, lrclk_oe, bclk_int, lrclk_int;
   logic [1:0] mode_ratio, fmt_code;
   logic [7:0] misc_eff;

   always #4 mclk = ~mclk;

   aud_sport_mode_ctl u_dut (.*);

   int  checks = 0, errors = 0;
   bit  done = 0;

   typedef struct { string req; int exp; } item_t;
   item_t exp_q[$];

   // driver side: expected result into the scoreboard
   task automatic push(input string req, input int exp);
      exp_q.push_back('{req, exp});
   endtask

   // monitor side: pop and compare against what the ports show
   task automatic pop_cmp(input int act);
      item_t it;
      checks++;
      if (exp_q.size() == 0) it = '{"none", -1};
      else it = exp_q.pop_front();
      if (act != it.exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", it.req, act, it.exp);
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      push(req, exp);
      pop_cmp(act);
   endtask

   task automatic nx(input int n);
      repeat (n) @(negedge mclk);
   endtask

   task automatic meas_bclk(output int per);
      logic p;
      int   g;
      per = 0;
      p = bclk_out; g = 0;
      do begin nx(1); g++; if (!p && bclk_out) break; p = bclk_out; end while (g < 200);
      p = bclk_out; g = 0;
      do begin nx(1); per++; if (!p && bclk_out) break; p = bclk_out; end while (per < 200);
   endtask

   task automatic meas_lr(output int nrise, output int coinc);
      logic pl, pb;
      int   g;
      nrise = 0; coinc = 1;
      pl = lrclk_out; g = 0;
      do begin nx(1); g++; end while (lrclk_out == pl && g < 2000);
      pl = lrclk_out; pb = bclk_out;
      do begin
         nx(1);
         if (!pb && bclk_out) nrise++;
         if (lrclk_out != pl && !(pb && !bclk_out)) coinc = 0;
         pb = bclk_out;
      end while (lrclk_out == pl && nrise < 2000);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int per, nr, co;
      nx(3);
      chk("R4 reset oe", bclk_oe, 0);
      chk("R4 reset slave", mode_slave, 1);
      rst_n = 1'b1;
      cfg_slave = 1'b0; cfg_ratio = 2'b00; cfg_fmt = 2'b10;
      nx(2);
      chk("R2 reg role", mode_slave, 0);
      chk("R2 reg fmt", fmt_code, 2);
      chk("R4 master oe", bclk_oe & lrclk_oe, 1);
      meas_bclk(per); chk("R6 256fs period", per, 4);
      cfg_ratio = 2'b01; nx(2);
      meas_bclk(per); chk("R6 512fs period", per, 8);
      cfg_ratio = 2'b10; nx(2);
      meas_bclk(per); chk("R6 1024fs period", per, 16);
      cfg_ratio = 2'b11; nx(2);
      meas_bclk(per); chk("R6 code 11 period", per, 4);
      cfg_ratio = 2'b00; nx(2);
      meas_lr(nr, co);
      chk("R7 bclk per half frame", nr, 32);
      chk("R7 lr on bclk fall", co, 1);
      meas_lr(nr, co);
      chk("R7 second half", nr, 32);
      // R9 restart on ratio change
      nx(37);
      cfg_ratio = 2'b01; nx(1);
      chk("R9 restart bclk", bclk_out, 0);
      chk("R9 restart lrclk", lrclk_out, 0);
      nx(3); chk("R9 still low", bclk_out, 0);
      nx(1); chk("R9 first rise", bclk_out, 1);
      // R3 register path
      cfg_misc = 8'hA5; nx(1);
      chk("R3 reg misc", misc_eff, 8'hA5);
      // R8 and R1 strap control
      cfg_ratio = 2'b10; nx(2);
      pin_ctl_en = 1'b1; strap_slave = 1'b0; strap_ratio_hi = 1'b1; strap_fmt = 2'b01;
      nx(2);
      chk("R8 before third edge", mode_ratio, 2);
      nx(1);
      chk("R8 third edge", mode_ratio, 1);
      chk("R1 strap fmt", fmt_code, 1);
      chk("R1 pinctl flag", mode_pinctl, 1);
      chk("R3 misc default", misc_eff, 0);
      cfg_misc = 8'h3C; cfg_fmt = 2'b11; cfg_ratio = 2'b00; nx(2);
      chk("R3 misc ignores reg", misc_eff, 0);
      chk("R1 fmt ignores reg", fmt_code, 1);
      meas_bclk(per); chk("R1 strap 512fs period", per, 8);
      strap_ratio_hi = 1'b0; nx(2);
      chk("R8 ratio pin latency", mode_ratio, 1);
      nx(1);
      chk("R1 strap 256fs code", mode_ratio, 0);
      meas_bclk(per); chk("R1 strap 256fs period", per, 4);
      strap_slave = 1'b1; nx(3);
      chk("R1 strap slave", mode_slave, 1);
      chk("R4 slave oe", bclk_oe | lrclk_oe, 0);
      chk("R4 slave out low", bclk_out | lrclk_out, 0);
      bclk_in = 1'b1; lrclk_in = 1'b0; #1;
      chk("R5 bclk pass", bclk_int, 1);
      chk("R5 lrclk pass", lrclk_int, 0);
      bclk_in = 1'b0; lrclk_in = 1'b1; #1;
      chk("R5 bclk pass low", bclk_int, 0);
      chk("R5 lrclk pass high", lrclk_int, 1);
      pin_ctl_en = 1'b0; cfg_slave = 1'b1; nx(3);
      chk("R2 back to reg", mode_pinctl, 0);
      chk("R3 reg misc restored", misc_eff, 8'h3C);
      chk("R2 reg fmt restored", fmt_code, 3);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule